// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block moves processor context between the working registers and a downward-growing stack kept in byte-wide memory. The surrounding core presents one of five commands together with the current condition code byte, accumulator, index register and program counter. The sequencer then walks through a fixed schedule of memory cycles and reports completion with a one-cycle done pulse. The commands are: save the full context and jump through an interrupt vector, restore the full context, save only the return address and jump to a call target, restore only the return address, and reinitialise the stack pointer.

The stack occupies a 64-byte window from 0x00C0 up to 0x00FF. Only the low six bits of the pointer ever change, so overflow and underflow wrap inside the window and never touch memory outside it. The vector address and the call target are plain inputs; choosing a vector, arbitrating interrupts and decoding instructions all happen elsewhere. Every command takes the same number of cycles on every run, so the core can schedule around it without a handshake.

The restored values appear on the register outputs and stay there until the next command. Each new command first copies the register inputs into those outputs, so a partial save or restore leaves the other registers at the values that were presented.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset, sp_out is 0x00FF, done and mem_we are low, and cc_out, a_out, x_out and pc_out are zero.
- R2: sp_out always lies in 0x00C0..0x00FF. Each push lowers it by one, and each pop raises it by one, modulo 64 inside that window (0x00C0 minus one gives 0x00FF).
- R3: Interrupt entry writes five bytes at the pointer and moves the pointer down after each write, in this order: PC low, PC high, X, A, CC. The CC value written is cc_in unchanged.
- R4: After saving, interrupt entry sets bit 3 (the interrupt mask) of cc_out. It then loads pc_out high byte from the byte at vec_addr and low byte from vec_addr+1.
- R5: Return from interrupt reads five bytes, moving the pointer up before each read, into CC, A, X, PC high and PC low in that order. The mask bit after the return equals bit 3 of the stacked CC byte.
- R6: A call pushes only PC low then PC high and loads pc_out from call_target. A subroutine return pops only PC high then PC low.
- R7: Command codes are 0 entry, 1 return from interrupt, 2 call, 3 subroutine return and 4 pointer reset. Counting the cycle in which the command is presented as cycle 1, done is high only in cycle 10, 9, 6, 6 or 2 respectively.
- R8: The pointer-reset command writes no memory and sets sp_out to 0x00FF.
- R9: A command presented while an operation is running is ignored. Codes 5, 6 and 7 are ignored: they produce no done, no write and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Command selector (see R7) |
| cc_in | input | 8 | Condition code byte to save |
| a_in | input | 8 | Accumulator to save |
| x_in | input | 8 | Index register to save |
| pc_in | input | 16 | Return address to save |
| vec_addr | input | 16 | Address of the two-byte interrupt vector |
| call_target | input | 16 | Destination of a call |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as mem_addr |
| mem_we | output | 1 | Write strobe |
| cc_out | output | 8 | Condition code result |
| a_out | output | 8 | Accumulator result |
| x_out | output | 8 | Index register result |
| pc_out | output | 16 | Program counter result |
| sp_out | output | 16 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
A step counter that skips or repeats shows up as a wrong done cycle and a wrong write count in the same operation. A slip in the pointer shows up as bytes landing at the wrong addresses, which the bench sees in the next restore or when it inspects memory. Long runs of calls and returns that wrap the window twice expose any pointer arithmetic that escapes the six-bit field: a sweep of forty calls and forty returns compares every return address against the wrap-aware expected slot. A mask bit that is restored from the wrong place is visible on cc_out straight after the return completes.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;

  typedef enum logic [2:0] {
    OP_ENTER = 3'd0,
    OP_RTI   = 3'd1,
    OP_CALL  = 3'd2,
    OP_RTS   = 3'd3,
    OP_RSP   = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SEL_PCL = 3'd0,
    SEL_PCH = 3'd1,
    SEL_X   = 3'd2,
    SEL_A   = 3'd3,
    SEL_CC  = 3'd4
  } sel_e;

  localparam int STEP_W = 4;
  typedef logic [STEP_W-1:0] step_t;

  typedef struct packed {
    logic push;
    logic pop;
    sel_e sel;
    logic set_mask;
    logic vec_hi;
    logic vec_lo;
    logic jump;
    logic sp_init;
  } act_t;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  // Index of the final busy step; done is raised in that step.
  function automatic step_t op_last(input op_e op);
    case (op)
      OP_ENTER: return step_t'(9);
      OP_RTI:   return step_t'(8);
      OP_CALL:  return step_t'(5);
      OP_RTS:   return step_t'(5);
      default:  return step_t'(1);
    endcase
  endfunction

  // Move a pointer by one inside an aligned window given by its mask.
  function automatic logic [15:0] ptr_move(input logic [15:0] ptr,
                                           input logic [15:0] win_mask,
                                           input logic up);
    logic [15:0] moved;
    moved = up ? (ptr + 16'd1) : (ptr - 16'd1);
    return (ptr & ~win_mask) | (moved & win_mask);
  endfunction

  function automatic act_t push_of(input sel_e s);
    act_t a;
    a = '0;
    a.push = 1'b1;
    a.sel  = s;
    return a;
  endfunction

  function automatic act_t pop_of(input sel_e s);
    act_t a;
    a = '0;
    a.pop = 1'b1;
    a.sel = s;
    return a;
  endfunction

  // Per-step action table for each operation.
  function automatic act_t step_action(input op_e op, input step_t step);
    act_t a;
    a = '0;
    case (op)
      OP_ENTER: begin
        case (step)
          step_t'(1): a = push_of(SEL_PCL);
          step_t'(2): a = push_of(SEL_PCH);
          step_t'(3): a = push_of(SEL_X);
          step_t'(4): a = push_of(SEL_A);
          step_t'(5): a = push_of(SEL_CC);
          step_t'(6): a.set_mask = 1'b1;
          step_t'(7): a.vec_hi = 1'b1;
          step_t'(8): a.vec_lo = 1'b1;
          default:    a = '0;
        endcase
      end
      OP_RTI: begin
        case (step)
          step_t'(1): a = pop_of(SEL_CC);
          step_t'(2): a = pop_of(SEL_A);
          step_t'(3): a = pop_of(SEL_X);
          step_t'(4): a = pop_of(SEL_PCH);
          step_t'(5): a = pop_of(SEL_PCL);
          default:    a = '0;
        endcase
      end
      OP_CALL: begin
        case (step)
          step_t'(1): a = push_of(SEL_PCL);
          step_t'(2): a = push_of(SEL_PCH);
          step_t'(3): a.jump = 1'b1;
          default:    a = '0;
        endcase
      end
      OP_RTS: begin
        case (step)
          step_t'(1): a = pop_of(SEL_PCH);
          step_t'(2): a = pop_of(SEL_PCL);
          default:    a = '0;
        endcase
      end
      OP_RSP: begin
        if (step == step_t'(1)) a.sp_init = 1'b1;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/ctx_step_ctrl.sv
module ctx_step_ctrl
  import ctx_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  op_e   start_op,
  output logic  busy,
  output op_e   cur_op,
  output step_t step,
  output logic  done
);

  logic at_last;
  assign at_last = (step == op_last(cur_op));
  assign done    = busy && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur_op <= OP_ENTER;
      step   <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cur_op <= start_op;
      step   <= step_t'(1);
    end else if (busy) begin
      if (at_last) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + step_t'(1);
      end
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the schedule advances one step per cycle with no stalls
  p_step_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && step == ($past(step) + step_t'(1))));

  // R9: a new operation only begins from idle
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/ctx_stack_ptr.sv
module ctx_stack_ptr
  import ctx_seq_pkg::*;
#(
  parameter logic [15:0] STACK_BASE  = 16'h00C0,
  parameter int          STACK_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec,
  input  logic        inc,
  input  logic        init,
  output logic [15:0] sp
);

  localparam logic [15:0] WIN_MASK = 16'(STACK_DEPTH - 1);
  localparam logic [15:0] SP_TOP   = STACK_BASE | WIN_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)     sp <= SP_TOP;
    else if (init)  sp <= SP_TOP;
    else if (dec)   sp <= ptr_move(sp, WIN_MASK, 1'b0);
    else if (inc)   sp <= ptr_move(sp, WIN_MASK, 1'b1);
  end

  // R2: the pointer never leaves its window
  p_sp_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sp & ~WIN_MASK) == STACK_BASE);

  // R9: with no push, pop or init the pointer holds
  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec || inc || init) |=> $stable(sp));

  // R8: the reset command lands on the window top
  p_sp_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (sp == SP_TOP));

endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
  import ctx_seq_pkg::*;
#(
  parameter int MASK_BIT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  cc_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  x_in,
  input  logic [15:0] pc_in,
  input  logic [15:0] vec_in,
  input  logic [15:0] tgt_in,
  input  act_t        act,
  input  logic [7:0]  rdata,
  output logic [7:0]  cc_q,
  output logic [7:0]  a_q,
  output logic [7:0]  x_q,
  output logic [15:0] pc_q,
  output logic [15:0] vec_q,
  output logic [7:0]  push_byte
);

  logic [15:0] tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q  <= '0;
      a_q   <= '0;
      x_q   <= '0;
      pc_q  <= '0;
      vec_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      cc_q  <= cc_in;
      a_q   <= a_in;
      x_q   <= x_in;
      pc_q  <= pc_in;
      vec_q <= vec_in;
      tgt_q <= tgt_in;
    end else begin
      if (act.pop) begin
        case (act.sel)
          SEL_CC:  cc_q       <= rdata;
          SEL_A:   a_q        <= rdata;
          SEL_X:   x_q        <= rdata;
          SEL_PCH: pc_q[15:8] <= rdata;
          default: pc_q[7:0]  <= rdata;
        endcase
      end
      if (act.set_mask) cc_q[MASK_BIT] <= 1'b1;
      if (act.vec_hi)   pc_q[15:8]     <= rdata;
      if (act.vec_lo)   pc_q[7:0]      <= rdata;
      if (act.jump)     pc_q           <= tgt_q;
    end
  end

  always_comb begin
    case (act.sel)
      SEL_PCL: push_byte = pc_q[7:0];
      SEL_PCH: push_byte = pc_q[15:8];
      SEL_X:   push_byte = x_q;
      SEL_A:   push_byte = a_q;
      default: push_byte = cc_q;
    endcase
  end

  // R4: the mask bit is set once the save is complete
  p_mask_after_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act.set_mask |=> cc_q[MASK_BIT]);

  // R5: a CC pop takes the stacked byte, mask bit included
  p_pop_cc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act.pop && act.sel == SEL_CC) |=> (cc_q == $past(rdata)));

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_seq_pkg::*;
#(
  parameter logic [15:0] STACK_BASE  = 16'h00C0,
  parameter int          STACK_DEPTH = 64,
  parameter int          MASK_BIT    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_code,
  input  logic [7:0]  cc_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  x_in,
  input  logic [15:0] pc_in,
  input  logic [15:0] vec_addr,
  input  logic [15:0] call_target,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic [7:0]  cc_out,
  output logic [7:0]  a_out,
  output logic [7:0]  x_out,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic        done
);

  localparam logic [15:0] WIN_MASK = 16'(STACK_DEPTH - 1);

  logic        busy;
  logic        start;
  op_e         cur_op;
  step_t       step;
  act_t        act;
  logic [15:0] vec_q;
  logic [15:0] pop_addr;
  logic [7:0]  push_byte;

  assign start = cmd_valid && !busy && op_legal(cmd_code);

  ctx_step_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_op (op_e'(cmd_code)),
    .busy     (busy),
    .cur_op   (cur_op),
    .step     (step),
    .done     (done)
  );

  always_comb begin
    if (busy) act = step_action(cur_op, step);
    else      act = '0;
  end

  ctx_stack_ptr #(
    .STACK_BASE  (STACK_BASE),
    .STACK_DEPTH (STACK_DEPTH)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .dec   (act.push),
    .inc   (act.pop),
    .init  (act.sp_init),
    .sp    (sp_out)
  );

  ctx_regfile #(
    .MASK_BIT (MASK_BIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .cc_in     (cc_in),
    .a_in      (a_in),
    .x_in      (x_in),
    .pc_in     (pc_in),
    .vec_in    (vec_addr),
    .tgt_in    (call_target),
    .act       (act),
    .rdata     (mem_rdata),
    .cc_q      (cc_out),
    .a_q       (a_out),
    .x_q       (x_out),
    .pc_q      (pc_out),
    .vec_q     (vec_q),
    .push_byte (push_byte)
  );

  assign pop_addr = ptr_move(sp_out, WIN_MASK, 1'b1);

  always_comb begin
    if (act.push)        mem_addr = sp_out;
    else if (act.pop)    mem_addr = pop_addr;
    else if (act.vec_hi) mem_addr = vec_q;
    else if (act.vec_lo) mem_addr = vec_q + 16'd1;
    else                 mem_addr = sp_out;
  end

  assign mem_we    = act.push;
  assign mem_wdata = push_byte;

  // R3: stack writes stay inside the window
  p_write_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr & ~WIN_MASK) == STACK_BASE));

  // R3: every write is followed by a pointer decrement
  p_write_decrements_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == ptr_move($past(sp_out), WIN_MASK, 1'b0)));

  // R9: no memory write while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

endmodule

// File: tb/ctx_stack_seq_bench.sv
`timescale 1ns/1ps
module ctx_stack_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [7:0]  cc_in = 8'h00, a_in = 8'h00, x_in = 8'h00;
  logic [15:0] pc_in = 16'h0000, vec_addr = 16'h0000, call_target = 16'h0000;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_we;
  logic [7:0]  cc_out, a_out, x_out;
  logic [15:0] pc_out, sp_out;
  logic        done;

  logic        poke_en = 1'b0;
  logic [7:0]  poke_a = 8'h00;
  logic [7:0]  poke_d = 8'h00;
  logic [7:0]  mem [0:255];

  int checks = 0;
  int fails  = 0;
  int cyc;
  int wr;

  always #4 clk = ~clk;

  ctx_stack_seq u_ctx_stack_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cc_in(cc_in), .a_in(a_in), .x_in(x_in), .pc_in(pc_in),
    .vec_addr(vec_addr), .call_target(call_target),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .cc_out(cc_out), .a_out(a_out), .x_out(x_out),
    .pc_out(pc_out), .sp_out(sp_out), .done(done)
  );

  always @(posedge clk) begin
    if (mem_we)       mem[mem_addr[7:0]] <= mem_wdata;
    else if (poke_en) mem[poke_a] <= poke_d;
  end
  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ptr_after(input logic [15:0] p, input int delta);
    return 16'h00C0 | 16'((int'(p) + delta) & 63);
  endfunction

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // Present a command, count cycles to done and writes on the way.
  task automatic run_op(input logic [2:0] code, input bit noise);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    cyc = 1; wr = 0;
    while (cyc < 40) begin
      if (mem_we) wr++;
      if (done) break;
      @(negedge clk);
      cyc++;
      cmd_valid = noise; cmd_code = 3'd4;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] pre, nxt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp_out, 16'h00FF);
    chk("R1 done", done, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 pc", pc_out, 0);
    chk("R1 cc", cc_out, 0);
    rst_n = 1'b1;

    poke(8'h10, 8'hAB);
    poke(8'h11, 8'hCD);

    // Entry with mask clear in cc_in
    cc_in = 8'h05; a_in = 8'hA1; x_in = 8'h5B; pc_in = 16'h0F77; vec_addr = 16'h0010;
    run_op(3'd0, 1'b1);
    chk("R7 entry cycles", cyc, 10);
    chk("R3 entry writes", wr, 5);
    chk("R3 PCL at FF", mem[8'hFF], 8'h77);
    chk("R3 PCH at FE", mem[8'hFE], 8'h0F);
    chk("R3 X at FD", mem[8'hFD], 8'h5B);
    chk("R3 A at FC", mem[8'hFC], 8'hA1);
    chk("R3 CC at FB", mem[8'hFB], 8'h05);
    chk("R3 sp after entry", sp_out, 16'h00FA);
    chk("R4 mask set", cc_out, 8'h0D);
    chk("R4 vector pc", pc_out, 16'hABCD);

    // Return: stacked mask bit is 0, so mask clears; R9 noise ignored
    cc_in = 8'hEE; a_in = 8'hEE; x_in = 8'hEE; pc_in = 16'hEEEE;
    run_op(3'd1, 1'b1);
    chk("R7 rti cycles", cyc, 9);
    chk("R5 rti no writes", wr, 0);
    chk("R5 cc mask cleared", cc_out, 8'h05);
    chk("R5 a", a_out, 8'hA1);
    chk("R5 x", x_out, 8'h5B);
    chk("R5 pc", pc_out, 16'h0F77);
    chk("R5 sp back", sp_out, 16'h00FF);

    // Entry with mask set, then stacked CC altered to clear it
    cc_in = 8'h09; a_in = 8'h11; x_in = 8'h22; pc_in = 16'h1357;
    run_op(3'd0, 1'b0);
    chk("R3 CC unchanged on stack", mem[8'hFB], 8'h09);
    run_op(3'd1, 1'b0);
    chk("R5 mask kept from stack", cc_out, 8'h09);
    run_op(3'd0, 1'b0);
    poke(8'hFB, 8'h02);
    run_op(3'd1, 1'b0);
    chk("R5 mask from altered stack", cc_out, 8'h02);
    chk("R5 pc second", pc_out, 16'h1357);

    // Forty calls wrap the 64-byte window
    for (int k = 0; k < 40; k++) begin
      pre = sp_out;
      pc_in = 16'h2000 + 16'(k);
      call_target = 16'h3000 + 16'(k);
      run_op(3'd2, k[0]);
      nxt = ptr_after(pre, -1);
      chk("R7 call cycles", cyc, 6);
      chk("R6 call writes", wr, 2);
      chk("R6 call PCL", mem[pre[7:0]], 8'(k));
      chk("R6 call PCH", mem[nxt[7:0]], 8'h20);
      chk("R2 sp after call", sp_out, ptr_after(pre, -2));
      chk("R6 call target", pc_out, 16'h3000 + 16'(k));
    end

    // Forty returns: each finds the newest call stored in its slot
    for (int j = 0; j < 40; j++) begin
      pre = sp_out;
      pc_in = 16'hFFFF;
      run_op(3'd3, j[0]);
      chk("R7 rts cycles", cyc, 6);
      chk("R6 rts no writes", wr, 0);
      chk("R6 rts pc", pc_out, 16'h2000 + 16'(39 - (j % 32)));
      chk("R2 sp after rts", sp_out, ptr_after(pre, 2));
    end

    // Undefined codes ignored
    pc_in = 16'h4444; call_target = 16'h5555;
    run_op(3'd2, 1'b0);
    pre = sp_out;
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 3'(c);
      repeat (4) begin
        @(negedge clk);
        chk("R9 undefined no done", done, 0);
        chk("R9 undefined no write", mem_we, 0);
      end
      cmd_valid = 1'b0;
      chk("R9 undefined sp", sp_out, pre);
      chk("R9 undefined pc", pc_out, 16'h5555);
    end

    // Pointer reset
    run_op(3'd4, 1'b0);
    chk("R7 rsp cycles", cyc, 2);
    chk("R8 rsp no writes", wr, 0);
    chk("R8 sp top", sp_out, 16'h00FF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule